// File: doc/BRIEF.md
# Long-Press Reset Pulse Generator

This block turns a long press of a push button into a single system reset pulse. The active-low button input passes through a synchronizer and is then timed. Only an unbroken low lasting the full hold time fires a pulse, and that pulse always has the same length. Shorter presses are forgotten. Once the pulse has fired, a new one cannot start until the button has been let go.

The output is a pull-down enable that drives an external open-drain stage. A delay-select input picks a zero-delay factory mode, in which a press fires the pulse at once. This mode is captured only while the timer is idle and the button is up, so changing the pin during a press has no effect. The hold time and the pulse length are parameters counted in clock cycles.

Top module: `lp_reset_gen`

## Requirements
- R1: While `rst_ni` is low and after it is released, `pull_en_o` is 0. The encoding is: 1 = pull the reset line low, 0 = release it. The block never drives the line high.
- R2: In normal mode, suppose `btn_ni` is first sampled low at clock edge E0 and stays low. `pull_en_o` then rises just after edge E(HOLD_CYC+1). This delay is two synchronizer edges plus HOLD_CYC low samples.
- R3: A press of HOLD_CYC-1 or fewer cycles produces no pulse, and the timer clears on release.
- R4: A press of exactly HOLD_CYC cycles produces a pulse.
- R5: Every pulse lasts exactly PULSE_CYC cycles, whether the button is released or held during it.
- R6: A press held past the end of the pulse gives no second pulse. A new pulse needs the synchronized button to be seen high after the pulse has ended.
- R7: In test mode (latched delay-select = 1), a press first sampled at E0 raises `pull_en_o` just after E2, for PULSE_CYC cycles. A press of a single cycle is enough.
- R8: The delay-select value is captured only while the timer is idle and the synchronized button is high. A change of `dsel_i` during a press or during a pulse does not alter that press's timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timer clock |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| btn_ni | input | 1 | Push-button input, active low, asynchronous |
| dsel_i | input | 1 | Delay select: 1 = zero-delay test mode, 0 = normal hold |
| pull_en_o | output | 1 | Open-drain pull-down enable, 1 = reset asserted |

## Verification
In normal mode the output is due HOLD_CYC+1 edges after the first edge that samples the button low. In test mode it is due two edges after that edge. In both modes it falls PULSE_CYC edges after it rose. The bench drives inputs and samples `pull_en_o` on the falling clock edge, one cycle at a time. It compares each sample with a bench function of the press length, the mode and the cycle index, so a result one cycle early or late is caught. Every trial is followed by enough high cycles for the timer to return to idle before the next press.

// File: rtl/lp_reset_pkg.sv
package lp_reset_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_HOLD  = 2'd1,
    ST_PULSE = 2'd2,
    ST_WAIT  = 2'd3
  } lpr_state_e;
endpackage

// File: rtl/lpr_sync.sv
module lpr_sync #(
  parameter int unsigned STAGES    = 2,
  parameter bit          RESET_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stg_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stg
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[i] <= RESET_VAL;
        else if (i == 0) stg_q[i] <= d_i;
        else stg_q[i] <= stg_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/lpr_mode_latch.sv
module lpr_mode_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic upd_en_i,
  input  logic dsel_i,
  output logic test_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       test_o <= 1'b0;
    else if (upd_en_i) test_o <= dsel_i;
  end
endmodule

// File: rtl/lpr_timer.sv
module lpr_timer
  import lp_reset_pkg::*;
#(
  parameter int unsigned HOLD_CYC  = 750_000_000,
  parameter int unsigned PULSE_CYC = 40_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic btn_s_i,   // synchronized, active low
  input  logic test_i,
  output logic idle_o,
  output logic pull_o
);
  localparam int unsigned MAXC = (HOLD_CYC > PULSE_CYC) ? HOLD_CYC : PULSE_CYC;
  localparam int unsigned CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] HOLD_LAST  = CW'(HOLD_CYC - 1);
  localparam logic [CW-1:0] PULSE_LAST = CW'(PULSE_CYC - 1);

  lpr_state_e    st_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          cnt_q <= '0;
          if (!btn_s_i) begin
            // zero-delay mode or single-cycle hold fires on the first low sample
            if (test_i || HOLD_LAST == '0) st_q <= ST_PULSE;
            else begin
              st_q  <= ST_HOLD;
              cnt_q <= CW'(1);
            end
          end
        end
        ST_HOLD: begin
          if (btn_s_i) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
          end else if (cnt_q == HOLD_LAST) begin
            st_q  <= ST_PULSE;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
        ST_PULSE: begin
          if (cnt_q == PULSE_LAST) begin
            st_q  <= ST_WAIT;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
        ST_WAIT: begin
          if (btn_s_i) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign idle_o = (st_q == ST_IDLE);
  assign pull_o = (st_q == ST_PULSE);
endmodule

// File: rtl/lp_reset_gen.sv
module lp_reset_gen #(
  parameter int unsigned HOLD_CYC  = 750_000_000,
  parameter int unsigned PULSE_CYC = 40_000_000,
  parameter int unsigned SYNC_STG  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic btn_ni,
  input  logic dsel_i,
  output logic pull_en_o
);
  logic btn_s;
  logic test_q;
  logic idle;

  lpr_sync #(.STAGES(SYNC_STG), .RESET_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (btn_ni),
    .q_o   (btn_s)
  );

  lpr_mode_latch u_mode (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .upd_en_i(idle & btn_s),
    .dsel_i  (dsel_i),
    .test_o  (test_q)
  );

  lpr_timer #(.HOLD_CYC(HOLD_CYC), .PULSE_CYC(PULSE_CYC)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .btn_s_i(btn_s),
    .test_i (test_q),
    .idle_o (idle),
    .pull_o (pull_en_o)
  );
endmodule

// File: rtl/lp_reset_gen_chk.sv
module lp_reset_gen_chk #(
  parameter int unsigned HOLD_CYC  = 750_000_000,
  parameter int unsigned PULSE_CYC = 40_000_000
) (
  input logic clk_i,
  input logic rst_ni,
  input logic btn_s,
  input logic test_q,
  input logic pull_en_o
);
  localparam int unsigned MAXC = (HOLD_CYC > PULSE_CYC) ? HOLD_CYC : PULSE_CYC;
  localparam int unsigned CW   = $clog2(MAXC + 2);
  localparam logic [CW-1:0] CMAX = '1;

  logic [CW-1:0] low_run_q;
  logic [CW-1:0] pulse_run_q;
  logic          armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_run_q   <= '0;
      pulse_run_q <= '0;
      armed_q     <= 1'b1;
    end else begin
      if (btn_s) low_run_q <= '0;
      else if (low_run_q != CMAX) low_run_q <= low_run_q + CW'(1);
      if (!pull_en_o) pulse_run_q <= '0;
      else if (pulse_run_q != CMAX) pulse_run_q <= pulse_run_q + CW'(1);
      if (pull_en_o) armed_q <= 1'b0;
      else if (btn_s) armed_q <= 1'b1;
    end
  end

  always_comb begin
    if (!rst_ni) assert_rst_quiet_R1: assert (!pull_en_o);
  end

  assert_hold_met_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(pull_en_o) && !test_q) |-> (low_run_q >= CW'(HOLD_CYC)));

  assert_pulse_cap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pull_en_o |-> (pulse_run_q < CW'(PULSE_CYC)));

  assert_pulse_len_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pull_en_o) |-> (pulse_run_q == CW'(PULSE_CYC)));

  assert_rearm_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pull_en_o) |-> $past(armed_q));

  assert_mode_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(test_q) |-> $past(btn_s));
endmodule

bind lp_reset_gen lp_reset_gen_chk #(.HOLD_CYC(HOLD_CYC), .PULSE_CYC(PULSE_CYC)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .btn_s    (btn_s),
  .test_q   (test_q),
  .pull_en_o(pull_en_o)
);

// File: tb/lp_reset_gen_bench.sv
`timescale 1ns/1ps
module lp_reset_gen_bench;
  localparam int HOLD  = 20;
  localparam int PULSE = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic btn_n = 1'b1;
  logic dsel = 1'b0;
  logic pull;

  int  n_chk = 0;
  int  n_err = 0;
  bit  mode_m = 1'b0;

  always #2.5 clk = ~clk;

  lp_reset_gen #(.HOLD_CYC(HOLD), .PULSE_CYC(PULSE)) u_lp_reset_gen (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .btn_ni   (btn_n),
    .dsel_i   (dsel),
    .pull_en_o(pull)
  );

  function automatic bit fires(int len, bit tm);
    return tm ? (len >= 1) : (len >= HOLD);
  endfunction

  function automatic int start_edge(bit tm);
    return tm ? 2 : HOLD + 1;
  endfunction

  function automatic bit exp_pull(int t, int len, bit tm);
    int s;
    s = start_edge(tm);
    return fires(len, tm) && (t >= s) && (t < s + PULSE);
  endfunction

  task automatic chk(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: pull_en_o=%b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic set_mode(bit m);
    dsel = m;
    mode_m = m;
    repeat (4) @(negedge clk);
  endtask

  // press for len cycles; optionally flip dsel at cycle flip_at and restore before release
  task automatic run_trial(int len, string tag, int flip_at);
    int s, w;
    bit f;
    s = start_edge(mode_m);
    f = fires(len, mode_m);
    w = f ? (((len > s + PULSE) ? len : s + PULSE) + 6) : len + 6;
    btn_n = 1'b0;
    for (int t = 0; t < w; t++) begin
      @(posedge clk);
      @(negedge clk);
      chk((t == s) ? "R2" : tag, pull, exp_pull(t, len, mode_m));
      if (flip_at >= 0 && t == flip_at) dsel = ~mode_m;
      if (flip_at >= 0 && t == len - 2) dsel = mode_m;
      btn_n = (t + 1 < len) ? 1'b0 : 1'b1;
    end
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk("R1", pull, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", pull, 1'b0);

    run_trial(HOLD - 1, "R3", -1);
    run_trial(3, "R3", -1);
    run_trial(HOLD, "R4", -1);
    run_trial(HOLD + 2, "R5", -1);
    run_trial(HOLD + PULSE + 15, "R6", -1);
    run_trial(HOLD + 10, "R8", 3);

    set_mode(1'b1);
    run_trial(1, "R7", -1);
    run_trial(30, "R7", -1);
    run_trial(12, "R8", 1);
    set_mode(1'b0);
    run_trial(HOLD, "R8", -1);

    for (int k = 0; k < 40; k++) begin
      int len;
      bit m;
      m = (($urandom % 4) == 0);
      if (m != mode_m) set_mode(m);
      case ($urandom % 5)
        0: len = 1 + int'($urandom % (HOLD - 1));
        1: len = HOLD - 1;
        2: len = HOLD;
        3: len = HOLD + int'($urandom % PULSE);
        default: len = HOLD + PULSE + 2 + int'($urandom % 10);
      endcase
      run_trial(len, m ? "R7" : (len < HOLD ? "R3" : (len > HOLD + PULSE ? "R6" : "R5")), -1);
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule